// File: doc/BRIEF.md
# Load/Store Exception Qualifier

This block sits beside the data-memory stage of a processor pipeline. For each decoded memory operation it decides whether the operation raises an alignment fault, whether a data-breakpoint event is reported, whether a prefetch hint is passed on to the data cache, whether the base-register write-back may commit, and whether a two-register coprocessor transfer is undefined. Address translation, the caches and the breakpoint comparators are outside the block. It only consumes their results: page cacheability, line residency, comparator hit and abort status.

Every input is sampled on a cycle where `valid_i` is high. The verdicts appear on the outputs one clock later. In any cycle whose previous sample had `valid_i` low, all outputs are low. The operation code on `op_i` uses this encoding:

| Code | Operation |
|------|-----------|
| 0 | load |
| 1 | store |
| 2 | doubleword load |
| 3 | doubleword store |
| 4 | prefetch hint |
| 5 | two-register transfer to a coprocessor |
| 6 | two-register transfer from a coprocessor |
| 7 | no operation |

Top module: `ls_excp_qual`

## Requirements
- R1: Every output is low while `rst_ni` is low. Every output is low in the cycle after a cycle with `valid_i` low. Otherwise the outputs reflect the inputs sampled on the previous rising edge.
- R2: `align_fault_o` is high one cycle after a valid doubleword operation (op 2 or 3) whose `addr_i[2:0]` equals 3'b100. It stays low for every other offset and for every other op code.
- R3: `bkpt_evt_o` is high one cycle after a valid load, store or doubleword operation (op 0 to 3) sampled with `bkpt_hit_i` high.
- R4: A prefetch hint (op 4) never raises `bkpt_evt_o`, even when `bkpt_hit_i` is high.
- R5: `pf_issue_o` is high one cycle after a valid prefetch hint (op 4) sampled with `cacheable_i` high and `line_hit_i` low. No other op code raises it.
- R6: A prefetch hint sampled with `cacheable_i` low, or with `line_hit_i` high, leaves `pf_issue_o` low.
- R7: `base_upd_o` is high one cycle after a valid load, store or doubleword operation (op 0 to 3) with `wb_req_i` high, `abort_i` low and no alignment fault. Ops 4 to 7 never raise it.
- R8: An operation sampled with `abort_i` high leaves `base_upd_o` low, so the base register keeps its prior value.
- R9: A doubleword operation that raises `align_fault_o` leaves `base_upd_o` low in the same cycle.
- R10: A two-register coprocessor transfer (op 5 or 6) raises `undef_o` when `cp_num_i` is not 0. With `cp_num_i` equal to 0, `undef_o` stays low. No other op code raises `undef_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | A decoded memory operation is present this cycle |
| op_i | input | 3 | Operation code (encoding in the table above) |
| addr_i | input | ADDR_W | Effective address |
| wb_req_i | input | 1 | Operation requests base-register write-back |
| cacheable_i | input | 1 | Target page is cacheable |
| line_hit_i | input | 1 | Target line is already resident in the data cache |
| bkpt_hit_i | input | 1 | Data-breakpoint comparator matched |
| abort_i | input | 1 | Data abort signalled for this operation |
| cp_num_i | input | CP_W | Coprocessor number of a two-register transfer |
| align_fault_o | output | 1 | Alignment fault |
| bkpt_evt_o | output | 1 | Data-breakpoint event |
| pf_issue_o | output | 1 | Forward the prefetch request to the cache |
| base_upd_o | output | 1 | Commit the base-register write-back |
| undef_o | output | 1 | Undefined-instruction indication |

## Verification
The bench builds the block with `ADDR_W` = 32 and `CP_W` = 4.

The 4-bit coprocessor field lets the bench sweep every coprocessor number from 0 to 15. This covers numbers 14 and 15 as well as the legal 0. Sweeping all eight low-order offsets of a 32-bit address separates the single faulting doubleword offset from the offsets that merely look unaligned.

Combinations of abort, alignment fault and write-back request, and prefetch hints over every cacheability and residency pairing, reach each suppression path. Idle cycles placed between operations confirm that outputs return low.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic [2:0] {
    OP_LD    = 3'd0,
    OP_ST    = 3'd1,
    OP_LDW   = 3'd2,
    OP_STW   = 3'd3,
    OP_PF    = 3'd4,
    OP_CPWR  = 3'd5,
    OP_CPRD  = 3'd6,
    OP_NONE  = 3'd7
  } mem_op_e;

  typedef struct packed {
    logic is_ls;
    logic is_dw;
    logic is_pf;
    logic is_cpx;
  } op_class_t;

  typedef struct packed {
    logic align_fault;
    logic bkpt_evt;
    logic pf_issue;
    logic base_upd;
    logic undef;
  } qual_t;
endpackage

// File: rtl/lsq_op_class.sv
module lsq_op_class
  import lsq_pkg::*;
(
  input  mem_op_e   op_i,
  output op_class_t cls_o
);
  always_comb begin
    cls_o = '0;
    unique case (op_i)
      OP_LD, OP_ST:     cls_o.is_ls = 1'b1;
      OP_LDW, OP_STW: begin
        cls_o.is_ls = 1'b1;
        cls_o.is_dw = 1'b1;
      end
      OP_PF:            cls_o.is_pf = 1'b1;
      OP_CPWR, OP_CPRD: cls_o.is_cpx = 1'b1;
      default:          cls_o = '0;
    endcase
  end
endmodule

// File: rtl/lsq_qualify.sv
module lsq_qualify
  import lsq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CP_W   = 4
) (
  input  op_class_t         cls_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wb_req_i,
  input  logic              cacheable_i,
  input  logic              line_hit_i,
  input  logic              bkpt_hit_i,
  input  logic              abort_i,
  input  logic [CP_W-1:0]   cp_num_i,
  output qual_t             q_o
);
  localparam int          DW_LSB   = 3;
  localparam logic [2:0]  DW_BAD   = 3'b100;
  localparam logic [CP_W-1:0] CP_OK = '0;

  logic dw_misal;

  assign dw_misal = cls_i.is_dw && (addr_i[DW_LSB-1:0] == DW_BAD);

  always_comb begin
    q_o             = '0;
    q_o.align_fault = dw_misal;
    // prefetch never reaches the breakpoint unit
    q_o.bkpt_evt    = cls_i.is_ls && bkpt_hit_i;
    q_o.pf_issue    = cls_i.is_pf && cacheable_i && !line_hit_i;
    // any abort, including alignment, restores the base
    q_o.base_upd    = cls_i.is_ls && wb_req_i && !abort_i && !dw_misal;
    q_o.undef       = cls_i.is_cpx && (cp_num_i != CP_OK);
  end
endmodule

// File: rtl/lsq_out_reg.sv
module lsq_out_reg
  import lsq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  qual_t q_i,
  output qual_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (valid_i) q_o <= q_i;
    else              q_o <= '0;
  end
endmodule

// File: rtl/ls_excp_qual.sv
module ls_excp_qual
  import lsq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CP_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wb_req_i,
  input  logic              cacheable_i,
  input  logic              line_hit_i,
  input  logic              bkpt_hit_i,
  input  logic              abort_i,
  input  logic [CP_W-1:0]   cp_num_i,
  output logic              align_fault_o,
  output logic              bkpt_evt_o,
  output logic              pf_issue_o,
  output logic              base_upd_o,
  output logic              undef_o
);
  op_class_t cls;
  qual_t     q_nxt;
  qual_t     q_r;

  lsq_op_class u_cls (
    .op_i  (mem_op_e'(op_i)),
    .cls_o (cls)
  );

  lsq_qualify #(.ADDR_W(ADDR_W), .CP_W(CP_W)) u_qual (
    .cls_i       (cls),
    .addr_i      (addr_i),
    .wb_req_i    (wb_req_i),
    .cacheable_i (cacheable_i),
    .line_hit_i  (line_hit_i),
    .bkpt_hit_i  (bkpt_hit_i),
    .abort_i     (abort_i),
    .cp_num_i    (cp_num_i),
    .q_o         (q_nxt)
  );

  lsq_out_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .q_i     (q_nxt),
    .q_o     (q_r)
  );

  assign align_fault_o = q_r.align_fault;
  assign bkpt_evt_o    = q_r.bkpt_evt;
  assign pf_issue_o    = q_r.pf_issue;
  assign base_upd_o    = q_r.base_upd;
  assign undef_o       = q_r.undef;
endmodule

// File: rtl/ls_excp_qual_chk.sv
module ls_excp_qual_chk #(
  parameter int ADDR_W = 32,
  parameter int CP_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wb_req_i,
  input logic              cacheable_i,
  input logic              line_hit_i,
  input logic              bkpt_hit_i,
  input logic              abort_i,
  input logic [CP_W-1:0]   cp_num_i,
  input logic              align_fault_o,
  input logic              bkpt_evt_o,
  input logic              pf_issue_o,
  input logic              base_upd_o,
  input logic              undef_o
);
  logic any_out;
  assign any_out = align_fault_o | bkpt_evt_o | pf_issue_o | base_upd_o | undef_o;

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !any_out); // R1

  AST_DW_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 3'd2 || op_i == 3'd3) && addr_i[2:0] == 3'b100
    |=> align_fault_o); // R2

  AST_BKPT_LS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i <= 3'd3 && bkpt_hit_i |=> bkpt_evt_o); // R3

  AST_PF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd4 |=> !bkpt_evt_o); // R4

  AST_PF_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd4 && (!cacheable_i || line_hit_i) |=> !pf_issue_o); // R6

  AST_ABORT_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && abort_i |=> !base_upd_o); // R8

  AST_FAULT_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_fault_o |-> !base_upd_o); // R9

  AST_CP_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 3'd5 || op_i == 3'd6) && cp_num_i != '0 |=> undef_o); // R10
endmodule

bind ls_excp_qual ls_excp_qual_chk #(.ADDR_W(ADDR_W), .CP_W(CP_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .op_i          (op_i),
  .addr_i        (addr_i),
  .wb_req_i      (wb_req_i),
  .cacheable_i   (cacheable_i),
  .line_hit_i    (line_hit_i),
  .bkpt_hit_i    (bkpt_hit_i),
  .abort_i       (abort_i),
  .cp_num_i      (cp_num_i),
  .align_fault_o (align_fault_o),
  .bkpt_evt_o    (bkpt_evt_o),
  .pf_issue_o    (pf_issue_o),
  .base_upd_o    (base_upd_o),
  .undef_o       (undef_o)
);

// File: tb/tb_ls_excp_qual.sv
`timescale 1ns/1ps
module tb_ls_excp_qual;
  localparam int ADDR_W  = 32;
  localparam int CP_W    = 4;
  localparam int CLK_PER = 10;

  typedef struct {
    logic [4:0] exp;
    string      tag;
  } item_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [2:0]        op_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              wb_req_i = 1'b0;
  logic              cacheable_i = 1'b0;
  logic              line_hit_i = 1'b0;
  logic              bkpt_hit_i = 1'b0;
  logic              abort_i = 1'b0;
  logic [CP_W-1:0]   cp_num_i = '0;
  logic              align_fault_o, bkpt_evt_o, pf_issue_o, base_upd_o, undef_o;

  item_t q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  always #(CLK_PER/2) clk_i = ~clk_i;

  ls_excp_qual #(.ADDR_W(ADDR_W), .CP_W(CP_W)) dut (.*);

  function automatic logic [4:0] outs();
    return {align_fault_o, bkpt_evt_o, pf_issue_o, base_upd_o, undef_o};
  endfunction

  // expected verdicts {align, bkpt, pf, upd, undef} derived from the requirements
  function automatic logic [4:0] model(logic v, logic [2:0] op, logic [2:0] lo,
                                       logic wb, logic c, logic h, logic b,
                                       logic ab, logic [CP_W-1:0] cp);
    logic ls, dw, pf, cx, al;
    if (!v) return 5'b0;
    ls = (op <= 3'd3);
    dw = (op == 3'd2) || (op == 3'd3);
    pf = (op == 3'd4);
    cx = (op == 3'd5) || (op == 3'd6);
    al = dw && (lo == 3'b100);
    return {al, ls && b, pf && c && !h, ls && wb && !ab && !al, cx && (cp != 0)};
  endfunction

  task automatic drive(logic v, logic [2:0] op, logic [ADDR_W-1:0] a, logic wb,
                       logic c, logic h, logic b, logic ab, logic [CP_W-1:0] cp,
                       string tag);
    item_t it;
    @(negedge clk_i);
    valid_i = v; op_i = op; addr_i = a; wb_req_i = wb; cacheable_i = c;
    line_hit_i = h; bkpt_hit_i = b; abort_i = ab; cp_num_i = cp;
    it.exp = model(v, op, a[2:0], wb, c, h, b, ab, cp);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(string tag);
    drive(1'b0, 3'd0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, tag);
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        n_chk++;
        if (outs() !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %b expected %b", it.tag, outs(), it.exp);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    valid_i = 1'b1; op_i = 3'd2; addr_i = 32'h4; bkpt_hit_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    n_chk++;
    if (outs() !== 5'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got %b expected %b", outs(), 5'b0);
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b1;

    // R2: doubleword offsets sweep, both directions, plus plain loads at 0x4
    for (int o = 0; o < 8; o++) begin
      drive(1'b1, 3'd2, 32'h1000 + o, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R2");
      drive(1'b1, 3'd3, 32'h2000 + o, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R2");
    end
    drive(1'b1, 3'd0, 32'h4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R2");
    drive(1'b1, 3'd4, 32'h4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R2");

    // R1: idle after activity, output must drop
    drive(1'b1, 3'd3, 32'h4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, "R1");
    idle("R1");
    idle("R1");

    // R3 / R4: breakpoint hit for each op code
    for (int op = 0; op < 8; op++)
      drive(1'b1, 3'(op), 32'h30, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3,
            (op == 4) ? "R4" : "R3");

    // R5 / R6: prefetch over cacheable x resident
    for (int m = 0; m < 4; m++)
      drive(1'b1, 3'd4, 32'h40, 1'b0, m[0], m[1], 1'b0, 1'b0, '0,
            (m == 1) ? "R5" : "R6");
    drive(1'b1, 3'd0, 32'h40, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R5");

    // R7 / R8 / R9: write-back combinations
    for (int op = 0; op < 8; op++)
      drive(1'b1, 3'(op), 32'h50, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R7");
    for (int op = 0; op < 4; op++)
      drive(1'b1, 3'(op), 32'h58, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '0, "R8");
    drive(1'b1, 3'd2, 32'h5C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R9");
    drive(1'b1, 3'd3, 32'h64, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '0, "R9");
    drive(1'b1, 3'd0, 32'h64, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R7");

    // R10: coprocessor number sweep, both directions
    for (int cp = 0; cp < 16; cp++) begin
      drive(1'b1, 3'd5, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'(cp), "R10");
      drive(1'b1, 3'd6, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'(cp), "R10");
    end
    drive(1'b1, 3'd0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd15, "R10");
    idle("R1");

    while (q.size() > 0) @(posedge clk_i);
    repeat (2) @(posedge clk_i);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule